// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the synchronised bus-write path of an 8-bit asynchronous NOR flash and its internal operation engine. Each bus write arrives as a one-clock strobe carrying a 21-bit address and a data byte. The decoder walks the keyed command handshakes. A short three-write path arms a byte program or switches the read mode. A longer six-write path starts a chip, sector or block erase. The decoder then emits a single-clock start pulse with the target address and data. It also holds the read-mode register that tells the read path what to return: the array, the identification codes, the query table or the security-ID space.

The decoder applies three gates. Write protection can fence off one 64 KB boot block, at the bottom or top of the map as chosen at build time. A busy input from the operation engine shuts out everything except erase suspend and resume. While an erase is parked, the suspended sector or block cannot be programmed. Any write that breaks a handshake drops the sequence and returns the read mode to array read. A handshake that stalls for a programmable number of idle clocks is dropped quietly, and the read mode is left as it was.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 0 (array read), `erase_suspended` is 0, and no start, request or `mode_chg` pulse is high.
- R2: Command writes compare only address bits 11..0; bits 20..12 are ignored. The writes 0xAAA/0xAA, 0x555/0x55, 0xAAA/0xA0 followed by any write X/D give a one-clock `start_prog` pulse on the clock after X/D, with `op_addr`=X and `op_data`=D.
- R3: The writes 0xAAA/0xAA, 0x555/0x55, 0xAAA/0x80, 0xAAA/0xAA, 0x555/0x55, then a sixth write, select an erase. 0x10 at 0xAAA pulses `start_chip_erase`. 0x50 at address A pulses `start_sec_erase`, with sector A[20:12] on `op_addr`. 0x30 at A pulses `start_blk_erase`, with block A[20:16] on `op_addr`. At most one start or request pulse is high in any clock.
- R4: After the two key writes, a third write at 0xAAA sets `rd_mode`: 0x90 sets 1 (identification), 0x98 sets 2 (query), 0x88 sets 3 (security ID) and 0xF0 sets 0. A lone 0xF0 write at any address also sets 0. `mode_chg` pulses on the clock when `rd_mode` takes a new value.
- R5: Any write that does not match the next expected handshake step drops the sequence, sets `rd_mode` to 0 and starts nothing. This includes a first write that is neither a key, 0xF0 nor a valid resume.
- R6: While `busy` is high, no start pulse is produced, `rd_mode` does not change (including on 0xF0), and sequence progress is frozen.
- R7: A write of 0xB0 at any address while `busy` and `erase_run` are high, after a sector or block erase, pulses `req_suspend` and sets `erase_suspended`. A later write of 0x30 at any address with `busy` low pulses `req_resume` and clears `erase_suspended`. 0xB0 is ignored while the running operation is not an erase or is a chip erase.
- R8: With `wp_n` low, program, sector erase and block erase aimed at the boot block are ignored, and chip erase is ignored altogether. The boot block is addresses 0x000000-0x00FFFF when `BOOT_TOP`=0, and 0x1F0000-0x1FFFFF otherwise. Targets outside the boot block are accepted.
- R9: When `idle_limit` is non-zero, a sequence left unfinished for `idle_limit` consecutive clocks without a write is dropped. `rd_mode` keeps its value. With `idle_limit`=0 no sequence is ever dropped this way.
- R10: While `erase_suspended` is high, a program aimed at the suspended sector (or block) is rejected and one aimed elsewhere is accepted. No erase of any kind starts.
- R11: A 0x30 write at any address with `busy` low and `erase_suspended` low is treated as a broken sequence (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-clock strobe per bus write |
| wr_addr | input | 21 | Address of the bus write |
| wr_data | input | 8 | Data byte of the bus write |
| busy | input | 1 | Operation engine is running a program or erase |
| erase_run | input | 1 | The running operation is an erase |
| wp_n | input | 1 | Low protects the boot block |
| idle_limit | input | 16 | Idle clocks before an unfinished sequence is dropped; 0 disables |
| start_prog | output | 1 | Start byte program pulse |
| start_sec_erase | output | 1 | Start sector erase pulse |
| start_blk_erase | output | 1 | Start block erase pulse |
| start_chip_erase | output | 1 | Start chip erase pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| mode_chg | output | 1 | Pulse when rd_mode changes |
| op_addr | output | 21 | Target address of the last started program or erase |
| op_data | output | 8 | Data of the last started program |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query, 3 security ID |
| erase_suspended | output | 1 | An erase is parked |

## Verification
The embedded properties assume that `wr_stb` is a single-clock pulse per bus write. They assume `erase_run` is high only while `busy` is high, and that `busy` is driven by an engine that this decoder started. They also assume `wp_n` is held steady across a handshake. The bench keeps within these limits by driving every write for exactly one clock at the falling edge. It raises `busy` and `erase_run` only between whole sequences, and it changes `wp_n` and `idle_limit` only while no sequence is open.

// File: rtl/fcd_pkg.sv
// Package: shared constants and types of the flash command decoder.
// Assumes an 8-bit data bus and 12 compared command-address bits.
package fcd_pkg;
    localparam int CMD_AW = 12;
    localparam int DW     = 8;

    localparam logic [CMD_AW-1:0] CA_FIRST  = 12'hAAA;
    localparam logic [CMD_AW-1:0] CA_SECOND = 12'h555;

    localparam logic [DW-1:0] D_KEY1   = 8'hAA;
    localparam logic [DW-1:0] D_KEY2   = 8'h55;
    localparam logic [DW-1:0] D_PROG   = 8'hA0;
    localparam logic [DW-1:0] D_ERASE  = 8'h80;
    localparam logic [DW-1:0] D_CHIP   = 8'h10;
    localparam logic [DW-1:0] D_SECT   = 8'h50;
    localparam logic [DW-1:0] D_BLOCK  = 8'h30;
    localparam logic [DW-1:0] D_SUSP   = 8'hB0;
    localparam logic [DW-1:0] D_RESUME = 8'h30;
    localparam logic [DW-1:0] D_IDENT  = 8'h90;
    localparam logic [DW-1:0] D_QUERY  = 8'h98;
    localparam logic [DW-1:0] D_SECID  = 8'h88;
    localparam logic [DW-1:0] D_EXIT   = 8'hF0;

    typedef enum logic [1:0] {
        MD_ARRAY = 2'd0,
        MD_IDENT = 2'd1,
        MD_QUERY = 2'd2,
        MD_SECID = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_PROG, CMD_SECT, CMD_BLOCK, CMD_CHIP,
        CMD_SUSP, CMD_RESUME, CMD_MODE, CMD_ABORT
    } cmd_e;

    typedef enum logic [1:0] {
        EK_NONE, EK_SECT, EK_BLOCK, EK_CHIP
    } ekind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PDATA, SQ_EKEY0, SQ_EKEY1, SQ_EKEY2
    } seq_e;
endpackage

// File: rtl/fcd_seq.sv
// Module: handshake walker. It classifies each bus write into a command
// class for the current clock and tracks handshake progress and the
// idle timeout. Assumes wr_stb is a one-clock pulse per bus write.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              busy,
    input  logic [CNT_W-1:0]  idle_limit,
    output cmd_e              cmd,
    output mode_e             cmd_mode
);
    seq_e             state, state_nx;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W:0]   idle_inc;
    logic             at_first, at_second;

    // Address match of the compared command bits
    always_comb begin
        at_first  = (cmd_addr == CA_FIRST);
        at_second = (cmd_addr == CA_SECOND);
    end

    // Decode the current write against the handshake position
    always_comb begin
        state_nx = state;
        cmd      = CMD_NONE;
        cmd_mode = MD_ARRAY;
        if (wr_stb) begin
            if (busy) begin
                if (wr_data == D_SUSP)        cmd = CMD_SUSP;
                else if (wr_data == D_RESUME) cmd = CMD_RESUME;
            end else begin
                state_nx = SQ_IDLE;
                cmd      = CMD_ABORT;
                case (state)
                    SQ_IDLE: begin
                        if (at_first && wr_data == D_KEY1) begin
                            state_nx = SQ_KEY1;
                            cmd      = CMD_NONE;
                        end else if (wr_data == D_EXIT) begin
                            cmd      = CMD_MODE;
                            cmd_mode = MD_ARRAY;
                        end else if (wr_data == D_RESUME) begin
                            cmd      = CMD_RESUME;
                        end
                    end
                    SQ_KEY1: begin
                        if (at_second && wr_data == D_KEY2) begin
                            state_nx = SQ_KEY2;
                            cmd      = CMD_NONE;
                        end
                    end
                    SQ_KEY2: begin
                        if (at_first) begin
                            case (wr_data)
                                D_PROG:  begin state_nx = SQ_PDATA; cmd = CMD_NONE; end
                                D_ERASE: begin state_nx = SQ_EKEY0; cmd = CMD_NONE; end
                                D_IDENT: begin cmd = CMD_MODE; cmd_mode = MD_IDENT; end
                                D_QUERY: begin cmd = CMD_MODE; cmd_mode = MD_QUERY; end
                                D_SECID: begin cmd = CMD_MODE; cmd_mode = MD_SECID; end
                                D_EXIT:  begin cmd = CMD_MODE; cmd_mode = MD_ARRAY; end
                                default: ;
                            endcase
                        end
                    end
                    SQ_PDATA: cmd = CMD_PROG;
                    SQ_EKEY0: begin
                        if (at_first && wr_data == D_KEY1) begin
                            state_nx = SQ_EKEY1;
                            cmd      = CMD_NONE;
                        end
                    end
                    SQ_EKEY1: begin
                        if (at_second && wr_data == D_KEY2) begin
                            state_nx = SQ_EKEY2;
                            cmd      = CMD_NONE;
                        end
                    end
                    SQ_EKEY2: begin
                        if (at_first && wr_data == D_CHIP) cmd = CMD_CHIP;
                        else if (wr_data == D_SECT)        cmd = CMD_SECT;
                        else if (wr_data == D_BLOCK)       cmd = CMD_BLOCK;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign idle_inc = {1'b0, idle_cnt} + 1'b1;

    // Advance handshake state and count idle clocks of an open sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            idle_cnt <= '0;
        end else if (wr_stb) begin
            state    <= state_nx;
            idle_cnt <= '0;
        end else if (state != SQ_IDLE && idle_limit != '0) begin
            if (idle_inc >= {1'b0, idle_limit}) begin
                state    <= SQ_IDLE;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_inc[CNT_W-1:0];
            end
        end
    end

    // R9
    idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> (idle_cnt == '0));
endmodule

// File: rtl/fcd_guard.sv
// Module: target gating. Flags a target that falls in the protected boot
// block and one that falls in the parked erase region. Assumes wp_n is
// steady for the duration of a handshake.
module fcd_guard
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int SEC_LSB  = 12,
    parameter int BLK_LSB  = 16,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic [ADDR_W-SEC_LSB-1:0] tgt_sect,
    input  logic                      wp_n,
    input  logic                      susp_on,
    input  ekind_e                    susp_kind,
    input  logic [ADDR_W-SEC_LSB-1:0] susp_sect,
    output logic                      boot_hit,
    output logic                      susp_hit
);
    localparam int SW = ADDR_W - SEC_LSB;
    localparam int BW = ADDR_W - BLK_LSB;
    localparam int BO = BLK_LSB - SEC_LSB;

    logic [BW-1:0] boot_idx;
    logic          sect_eq, blk_eq;

    generate
        if (BOOT_TOP) begin : g_top_boot
            assign boot_idx = '1;
        end else begin : g_bottom_boot
            assign boot_idx = '0;
        end
    endgenerate

    // Compare target with the boot block and the parked erase region
    always_comb begin
        sect_eq  = (tgt_sect == susp_sect);
        blk_eq   = (tgt_sect[SW-1:BO] == susp_sect[SW-1:BO]);
        boot_hit = !wp_n && (tgt_sect[SW-1:BO] == boot_idx);
        susp_hit = susp_on && ((susp_kind == EK_SECT  && sect_eq) ||
                               (susp_kind == EK_BLOCK && blk_eq));
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the flash command decoder. It registers start pulses, the
// read mode, the parked-erase state and the operation target. Assumes
// busy/erase_run come from the operation engine and erase_run implies busy.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int SEC_LSB  = 12,
    parameter int BLK_LSB  = 16,
    parameter bit BOOT_TOP = 1'b0,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              erase_run,
    input  logic              wp_n,
    input  logic [CNT_W-1:0]  idle_limit,
    output logic              start_prog,
    output logic              start_sec_erase,
    output logic              start_blk_erase,
    output logic              start_chip_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic              mode_chg,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        rd_mode,
    output logic              erase_suspended
);
    localparam int SW = ADDR_W - SEC_LSB;

    cmd_e    cmd;
    mode_e   cmd_mode;
    mode_e   mode_q, mode_nx;
    ekind_e  kind_q, kind_nx;
    logic [SW-1:0] esect_q, esect_nx;
    logic    susp_q, susp_nx;
    logic    boot_hit, susp_hit;
    logic    p_prog, p_sect, p_blk, p_chip, p_susp, p_res;

    fcd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .cmd_addr   (wr_addr[CMD_AW-1:0]),
        .wr_data    (wr_data),
        .busy       (busy),
        .idle_limit (idle_limit),
        .cmd        (cmd),
        .cmd_mode   (cmd_mode)
    );

    fcd_guard #(
        .ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB), .BOOT_TOP(BOOT_TOP)
    ) u_guard (
        .tgt_sect  (wr_addr[ADDR_W-1:SEC_LSB]),
        .wp_n      (wp_n),
        .susp_on   (susp_q),
        .susp_kind (kind_q),
        .susp_sect (esect_q),
        .boot_hit  (boot_hit),
        .susp_hit  (susp_hit)
    );

    // Gate the decoded command by protection, suspend and busy state
    always_comb begin
        p_prog = 1'b0; p_sect = 1'b0; p_blk = 1'b0;
        p_chip = 1'b0; p_susp = 1'b0; p_res = 1'b0;
        mode_nx  = mode_q;
        susp_nx  = susp_q;
        kind_nx  = kind_q;
        esect_nx = esect_q;
        case (cmd)
            CMD_PROG:   p_prog = !boot_hit && !susp_hit;
            CMD_SECT: begin
                if (!boot_hit && !susp_q) begin
                    p_sect   = 1'b1;
                    kind_nx  = EK_SECT;
                    esect_nx = wr_addr[ADDR_W-1:SEC_LSB];
                end
            end
            CMD_BLOCK: begin
                if (!boot_hit && !susp_q) begin
                    p_blk    = 1'b1;
                    kind_nx  = EK_BLOCK;
                    esect_nx = wr_addr[ADDR_W-1:SEC_LSB];
                end
            end
            CMD_CHIP: begin
                if (wp_n && !susp_q) begin
                    p_chip  = 1'b1;
                    kind_nx = EK_CHIP;
                end
            end
            CMD_SUSP: begin
                if (erase_run && !susp_q && (kind_q == EK_SECT || kind_q == EK_BLOCK)) begin
                    p_susp  = 1'b1;
                    susp_nx = 1'b1;
                end
            end
            CMD_RESUME: begin
                if (!busy) begin
                    if (susp_q) begin
                        p_res   = 1'b1;
                        susp_nx = 1'b0;
                    end else begin
                        mode_nx = MD_ARRAY;
                    end
                end
            end
            CMD_MODE:  mode_nx = cmd_mode;
            CMD_ABORT: mode_nx = MD_ARRAY;
            default: ;
        endcase
    end

    // Register pulses, mode, parked-erase state and target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_prog       <= 1'b0;
            start_sec_erase  <= 1'b0;
            start_blk_erase  <= 1'b0;
            start_chip_erase <= 1'b0;
            req_suspend      <= 1'b0;
            req_resume       <= 1'b0;
            mode_chg         <= 1'b0;
            mode_q           <= MD_ARRAY;
            susp_q           <= 1'b0;
            kind_q           <= EK_NONE;
            esect_q          <= '0;
            op_addr          <= '0;
            op_data          <= '0;
        end else begin
            start_prog       <= p_prog;
            start_sec_erase  <= p_sect;
            start_blk_erase  <= p_blk;
            start_chip_erase <= p_chip;
            req_suspend      <= p_susp;
            req_resume       <= p_res;
            mode_chg         <= (mode_nx != mode_q);
            mode_q           <= mode_nx;
            susp_q           <= susp_nx;
            kind_q           <= kind_nx;
            esect_q          <= esect_nx;
            if (p_prog || p_sect || p_blk) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign rd_mode         = mode_q;
    assign erase_suspended = susp_q;

    // R3
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_sec_erase, start_blk_erase,
                  start_chip_erase, req_suspend, req_resume}));
    // R6
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(start_prog || start_sec_erase || start_blk_erase || start_chip_erase));
    // R6
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_mode));
    // R8
    wp_chip_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !start_chip_erase);
    // R7
    resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> !erase_suspended);
    // R7
    suspend_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_suspended) |-> req_suspend);
    // R10
    parked_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_suspended |=> !(start_sec_erase || start_blk_erase || start_chip_erase));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
    localparam int AW = 21;
    localparam int CW = 16;
    localparam logic [5:0] PV_PROG = 6'b100000;
    localparam logic [5:0] PV_SECT = 6'b010000;
    localparam logic [5:0] PV_BLK  = 6'b001000;
    localparam logic [5:0] PV_CHIP = 6'b000100;
    localparam logic [5:0] PV_SUSP = 6'b000010;
    localparam logic [5:0] PV_RES  = 6'b000001;

    logic clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0;
    logic busy = 1'b0, erase_run = 1'b0, wp_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [CW-1:0] idle_limit = '0;
    logic start_prog, start_sec_erase, start_blk_erase, start_chip_erase;
    logic req_suspend, req_resume, mode_chg, erase_suspended;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic [1:0]    rd_mode;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [5:0] acc = '0;
    logic mchg_seen = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .erase_run(erase_run), .wp_n(wp_n),
        .idle_limit(idle_limit), .start_prog(start_prog),
        .start_sec_erase(start_sec_erase), .start_blk_erase(start_blk_erase),
        .start_chip_erase(start_chip_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .mode_chg(mode_chg), .op_addr(op_addr),
        .op_data(op_data), .rd_mode(rd_mode), .erase_suspended(erase_suspended)
    );

    wire [5:0] pv = {start_prog, start_sec_erase, start_blk_erase,
                     start_chip_erase, req_suspend, req_resume};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        acc = '0;
        mchg_seen = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        acc = acc | pv;
        mchg_seen = mchg_seen | mode_chg;
    endtask

    task automatic unlock(input logic [8:0] hi);
        wr({hi, 12'hAAA}, 8'hAA);
        wr({hi, 12'h555}, 8'h55);
    endtask

    task automatic cmd3(input logic [7:0] d);
        unlock(9'h000);
        wr(21'h000AAA, d);
    endtask

    task automatic cmd6(input logic [AW-1:0] a, input logic [7:0] d);
        cmd3(8'h80);
        unlock(9'h000);
        wr(a, d);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        cmd3(8'hA0);
        wr(a, d);
    endtask

    function automatic logic [AW-1:0] cyc_a(input int j);
        return (j == 1 || j == 4) ? 21'h000555 : 21'h000AAA;
    endfunction

    function automatic logic [7:0] cyc_d(input int j);
        case (j)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(rd_mode), 32'd0);
        chk("R1 pulses", 32'({pv, mode_chg}), 32'd0);
        chk("R1 suspended", 32'(erase_suspended), 32'd0);

        // R2 program, with varied don't-care high bits in command writes
        for (int i = 0; i < 16; i++) begin
            logic [AW-1:0] tgt;
            logic [7:0] dv;
            tgt = 21'(i * 21'h01F3A7 + 21'h010000);
            dv  = 8'(i * 37 + 1);
            clr();
            unlock(9'(i * 29));
            wr({9'(i * 13), 12'hAAA}, 8'hA0);
            wr(tgt, dv);
            chk("R2 program pulse", 32'(acc), 32'(PV_PROG));
            chk("R2 program addr", 32'(op_addr), 32'(tgt));
            chk("R2 program data", 32'(op_data), 32'(dv));
        end

        // R3 sector erase sweep
        for (int s = 1; s < 512; s += 37) begin
            clr();
            cmd6({s[8:0], 12'h123}, 8'h50);
            chk("R3 sector pulse", 32'(acc), 32'(PV_SECT));
            chk("R3 sector addr", 32'(op_addr[20:12]), 32'(s[8:0]));
        end
        // R3 block erase over every block
        for (int b = 0; b < 32; b++) begin
            clr();
            cmd6({b[4:0], 16'h0ABC}, 8'h30);
            chk("R3 block pulse", 32'(acc), 32'(PV_BLK));
            chk("R3 block addr", 32'(op_addr[20:16]), 32'(b[4:0]));
        end
        clr();
        cmd6(21'h1F0AAA, 8'h10);
        chk("R3 chip pulse", 32'(acc), 32'(PV_CHIP));

        // R4 read-mode entry and exit
        clr(); cmd3(8'h90);
        chk("R4 ident mode", 32'(rd_mode), 32'd1);
        chk("R4 mode_chg", 32'(mchg_seen), 32'd1);
        clr(); cmd3(8'h98);
        chk("R4 query mode", 32'(rd_mode), 32'd2);
        clr(); cmd3(8'h88);
        chk("R4 secid mode", 32'(rd_mode), 32'd3);
        clr(); cmd3(8'hF0);
        chk("R4 keyed exit", 32'(rd_mode), 32'd0);
        cmd3(8'h98);
        clr(); wr(21'h1A2345, 8'hF0);
        chk("R4 single exit", 32'(rd_mode), 32'd0);
        chk("R4 single exit mode_chg", 32'(mchg_seen), 32'd1);

        // R5 break each position of the six-write handshake
        for (int k = 0; k < 6; k++) begin
            cmd3(8'h90);
            clr();
            for (int j = 0; j <= k; j++) begin
                if (j == k) wr(cyc_a(j), 8'h00);
                else        wr(cyc_a(j), cyc_d(j));
            end
            chk("R5 abort mode", 32'(rd_mode), 32'd0);
            chk("R5 abort no start", 32'(acc), 32'd0);
        end
        clr(); prog(21'h02_4000, 8'h5A);
        chk("R5 restart after abort", 32'(acc), 32'(PV_PROG));

        // R6 busy freezes everything but suspend/resume
        cmd3(8'h90);
        @(negedge clk); busy = 1'b1;
        clr();
        cmd3(8'hF0);
        wr(21'h000123, 8'hF0);
        cmd6(21'h000AAA, 8'h10);
        prog(21'h030000, 8'h11);
        chk("R6 busy no start", 32'(acc), 32'd0);
        chk("R6 busy mode held", 32'(rd_mode), 32'd1);
        // R7 suspend ignored while the running operation is a program
        clr(); wr(21'h000000, 8'hB0);
        chk("R7 no suspend of program", 32'(acc), 32'd0);
        @(negedge clk); busy = 1'b0;
        wr(21'h000000, 8'hF0);

        // R7 suspend/resume of a sector erase
        clr(); cmd6(21'h005000, 8'h50);
        chk("R7 erase started", 32'(acc), 32'(PV_SECT));
        @(negedge clk); busy = 1'b1; erase_run = 1'b1;
        clr(); wr(21'h1ABCDE, 8'hB0);
        chk("R7 suspend pulse", 32'(acc), 32'(PV_SUSP));
        chk("R7 suspended flag", 32'(erase_suspended), 32'd1);
        @(negedge clk); busy = 1'b0; erase_run = 1'b0;
        // R10 program into parked sector rejected, elsewhere accepted
        clr(); prog(21'h005ABC, 8'h12);
        chk("R10 parked sector program", 32'(acc), 32'd0);
        clr(); prog(21'h006000, 8'h34);
        chk("R10 other sector program", 32'(acc), 32'(PV_PROG));
        clr(); cmd6(21'h040000, 8'h30);
        cmd6(21'h000AAA, 8'h10);
        chk("R10 no erase while parked", 32'(acc), 32'd0);
        clr(); wr(21'h0F0F0F, 8'h30);
        chk("R7 resume pulse", 32'(acc), 32'(PV_RES));
        chk("R7 suspended cleared", 32'(erase_suspended), 32'd0);
        // R11 resume with nothing parked acts as a broken sequence
        cmd3(8'h88);
        clr(); wr(21'h000777, 8'h30);
        chk("R11 stray resume pulse", 32'(acc), 32'd0);
        chk("R11 stray resume mode", 32'(rd_mode), 32'd0);
        // R7 chip erase cannot be suspended
        clr(); cmd6(21'h000AAA, 8'h10);
        @(negedge clk); busy = 1'b1; erase_run = 1'b1;
        wr(21'h000000, 8'hB0);
        chk("R7 chip erase not suspended", 32'(acc), 32'(PV_CHIP));
        @(negedge clk); busy = 1'b0; erase_run = 1'b0;

        // R8 write protection of the bottom boot block
        @(negedge clk); wp_n = 1'b0;
        for (int b = 0; b < 32; b++) begin
            clr();
            cmd6({b[4:0], 16'h1234}, 8'h30);
            chk("R8 protected block erase", 32'(acc), (b == 0) ? 32'd0 : 32'(PV_BLK));
        end
        for (int s = 0; s < 18; s++) begin
            clr();
            cmd6({4'h0, s[4:0], 12'h010}, 8'h50);
            chk("R8 protected sector erase", 32'(acc), (s < 16) ? 32'd0 : 32'(PV_SECT));
        end
        clr(); prog(21'h00ABCD, 8'h01);
        chk("R8 protected program", 32'(acc), 32'd0);
        clr(); prog(21'h010000, 8'h02);
        chk("R8 unprotected program", 32'(acc), 32'(PV_PROG));
        clr(); cmd6(21'h000AAA, 8'h10);
        chk("R8 chip erase blocked", 32'(acc), 32'd0);
        @(negedge clk); wp_n = 1'b1;
        clr(); prog(21'h00ABCD, 8'h03);
        chk("R8 boot program with wp high", 32'(acc), 32'(PV_PROG));

        // R9 idle timeout: back-to-back writes leave 1 idle clock, +g more
        idle_limit = 16'd4;
        for (int g = 0; g < 6; g++) begin
            clr();
            unlock(9'h000);
            repeat (g) @(negedge clk);
            wr(21'h000AAA, 8'hA0);
            wr(21'h003000, 8'(g));
            chk("R9 timeout window", 32'(acc), (g <= 2) ? 32'(PV_PROG) : 32'd0);
        end
        cmd3(8'h90);
        unlock(9'h000);
        repeat (6) @(negedge clk);
        chk("R9 mode kept on timeout", 32'(rd_mode), 32'd1);
        idle_limit = 16'd0;
        clr();
        unlock(9'h000);
        repeat (50) @(negedge clk);
        wr(21'h000AAA, 8'hA0);
        wr(21'h007000, 8'h77);
        chk("R9 limit zero never drops", 32'(acc), 32'(PV_PROG));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule